// File: doc/BRIEF.md
# Multi-Channel Compare Timer

This block is a register-mapped event timer. A 64-bit main counter advances by one on every clock while the global run bit is set, and a small set of comparator channels watch its low 32 bits. When the counter equals a channel's comparator, that channel latches a pending flag. The flag drives an interrupt level that stays high until software clears it.

Each channel is either one-shot, where the comparator is a fixed match target, or periodic, where the comparator is advanced by a stored reload period on every match. To load a periodic channel, software sets a set-value bit in the channel configuration. The next comparator write then loads the first target, and the write after that loads the reload period. A legacy routing switch moves the interrupts of channels 0 and 1 off the per-channel outputs and onto two dedicated lines. Software reads a capability word, a fixed tick length in femtoseconds, the counter halves, the channel state and the pending flags through a simple 32-bit read/write port. The port has a combinational read path and writes that take effect on the clock edge.

Address map (byte offsets): 0x000 capability, 0x004 tick period, 0x010 global control, 0x020 pending flags, 0x0F0 counter low word, 0x0F4 counter high word. Channel n has its configuration at 0x100 + n*0x20 and its comparator at 0x108 + n*0x20.

Top module: `evt_timer`

## Requirements
- R1: The capability word at 0x000 holds the channel count minus one in bits [4:0] and a legacy-routing capability flag in bit 8 (value 0x102 for three channels). The word at 0x004 returns the tick length parameter. Writes to both offsets have no effect.
- R2: The 64-bit counter counts up by one per clock only while global control bit 0 (run) is 1, and holds its value while run is 0. A write to 0x0F0 or 0x0F4 loads the low or high 32 bits, and the carry out of the low word enters the high word.
- R3: Reading 0x0F0 returns the counter's low word and reading 0x0F4 returns its high word. Both read 0 after reset.
- R4: A channel whose configuration bit 0 (enable) is 1 and bit 1 (periodic) is 0 sets its pending flag one clock after the cycle in which the counter low word equals its comparator. Its comparator keeps its value.
- R5: An enabled periodic channel that matches gets its comparator advanced by its reload period on the same clock edge that sets its pending flag.
- R6: Writing configuration bit 2 (set-value) as 1 makes the next comparator write load the match target and the write after it load the reload period. Bit 2 always reads back as 0. Bit 3 (force 32-bit) is stored and read back.
- R7: A channel with enable at 0 never sets its pending flag, and its comparator does not move when the counter passes it.
- R8: Writing 1 to bit n of the pending register at 0x020 clears channel n's flag. Writing 0 leaves it unchanged. If a match and a clearing write fall in the same cycle, the flag stays set.
- R9: When global control bit 1 (legacy routing) is 1, the pending flags of channels 0 and 1 drive leg_tick_o and leg_rtc_o, and irq_o[0] and irq_o[1] are held at 0.
- R10: irq_o[n] is the level of channel n's pending flag whenever that channel is not legacy-routed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | NCH | Per-channel interrupt levels |
| leg_tick_o | output | 1 | Legacy line for channel 0 |
| leg_rtc_o | output | 1 | Legacy line for channel 1 |

## Verification
A comparator match and a software write that clears the same channel's pending flag can land on the same clock edge. This race decides whether an interrupt is lost. The bench stops the counter, sets it to zero, arms a periodic channel with an 8-tick period, and counts cycles so that the clearing write reaches its edge in the very cycle the counter equals the advanced comparator. The bench judges the result by the flag still reading 1 afterwards and by a second clear, one cycle later, removing it.

// File: rtl/evt_timer.sv
module evt_timer #(
  parameter int          NCH     = 3,
  parameter logic [31:0] TICK_FS = 32'd69841279,
  parameter int          AW      = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic [NCH-1:0] irq_o,
  output logic           leg_tick_o,
  output logic           leg_rtc_o
);

  localparam int A_ID    = 'h000;
  localparam int A_PER   = 'h004;
  localparam int A_GCTL  = 'h010;
  localparam int A_STS   = 'h020;
  localparam int A_CLO   = 'h0F0;
  localparam int A_CHI   = 'h0F4;
  localparam int A_CH    = 'h100;
  localparam int A_STEP  = 'h20;
  localparam int A_CMPO  = 'h08;
  localparam logic [4:0]  NCH_M1 = 5'(NCH - 1);
  localparam logic        LEG_OK = (NCH >= 2);

  logic            g_run, g_leg;
  logic [63:0]     cnt, cnt_nx;
  logic [NCH-1:0]  ch_en, ch_per, ch_f32, sv_a, sv_b, sts, hit;
  logic [NCH-1:0]  cfg_wr, cmp_wr, cfg_rd, cmp_rd;
  logic [31:0]     cmp [NCH];
  logic [31:0]     prd [NCH];

  wire wr_gctl = bus_we && (bus_addr == AW'(A_GCTL));
  wire wr_sts  = bus_we && (bus_addr == AW'(A_STS));
  wire wr_clo  = bus_we && (bus_addr == AW'(A_CLO));
  wire wr_chi  = bus_we && (bus_addr == AW'(A_CHI));

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      assign cfg_rd[g] = (bus_addr == AW'(A_CH + g*A_STEP));
      assign cmp_rd[g] = (bus_addr == AW'(A_CH + g*A_STEP + A_CMPO));
      assign cfg_wr[g] = bus_we && cfg_rd[g];
      assign cmp_wr[g] = bus_we && cmp_rd[g];
      assign hit[g]    = g_run && ch_en[g] && (cnt[31:0] == cmp[g]);
      if (g < 2) begin : g_lg
        assign irq_o[g] = sts[g] && !g_leg;
      end else begin : g_nl
        assign irq_o[g] = sts[g];
      end

      AST_ONESHOT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[g] && !ch_per[g] && !cmp_wr[g]) |=> $stable(cmp[g]));  // R4
      AST_PERIODIC_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[g] && ch_per[g] && !cmp_wr[g]) |=> (cmp[g] == $past(cmp[g]) + $past(prd[g])));  // R5
      AST_STS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        hit[g] |=> sts[g]);  // R8
      AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ch_en[g] && !sts[g]) |=> !sts[g]);  // R7
    end
  endgenerate

  assign leg_tick_o = g_leg && sts[0];
  assign leg_rtc_o  = g_leg && sts[1];

  always_comb begin
    cnt_nx = g_run ? cnt + 64'd1 : cnt;
    if (wr_clo) cnt_nx[31:0]  = bus_wdata;
    if (wr_chi) cnt_nx[63:32] = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g_run  <= 1'b0;
      g_leg  <= 1'b0;
      cnt    <= '0;
      ch_en  <= '0;
      ch_per <= '0;
      ch_f32 <= '0;
      sv_a   <= '0;
      sv_b   <= '0;
      sts    <= '0;
      for (int n = 0; n < NCH; n++) begin
        cmp[n] <= '1;
        prd[n] <= '0;
      end
    end else begin
      cnt <= cnt_nx;
      if (wr_gctl) begin
        g_run <= bus_wdata[0];
        g_leg <= bus_wdata[1] && LEG_OK;
      end
      for (int n = 0; n < NCH; n++) begin
        if (cfg_wr[n]) begin
          ch_en[n]  <= bus_wdata[0];
          ch_per[n] <= bus_wdata[1];
          ch_f32[n] <= bus_wdata[3];
          if (bus_wdata[2]) begin
            sv_a[n] <= 1'b1;
            sv_b[n] <= 1'b0;
          end
        end
        if (cmp_wr[n]) begin
          if (sv_a[n]) begin
            cmp[n]  <= bus_wdata;
            sv_a[n] <= 1'b0;
            sv_b[n] <= 1'b1;
          end else if (sv_b[n]) begin
            prd[n]  <= bus_wdata;
            sv_b[n] <= 1'b0;
          end else begin
            cmp[n] <= bus_wdata;
          end
        end else if (hit[n] && ch_per[n]) begin
          cmp[n] <= cmp[n] + prd[n];
        end
        sts[n] <= hit[n] || (sts[n] && !(wr_sts && bus_wdata[n]));
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(A_ID))   bus_rdata = {23'd0, LEG_OK, 3'd0, NCH_M1};
    if (bus_addr == AW'(A_PER))  bus_rdata = TICK_FS;
    if (bus_addr == AW'(A_GCTL)) bus_rdata = {30'd0, g_leg, g_run};
    if (bus_addr == AW'(A_STS))  bus_rdata = 32'(sts);
    if (bus_addr == AW'(A_CLO))  bus_rdata = cnt[31:0];
    if (bus_addr == AW'(A_CHI))  bus_rdata = cnt[63:32];
    for (int n = 0; n < NCH; n++) begin
      if (cfg_rd[n]) bus_rdata = {28'd0, ch_f32[n], 1'b0, ch_per[n], ch_en[n]};
      if (cmp_rd[n]) bus_rdata = cmp[n];
    end
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!g_run && !wr_clo && !wr_chi) |=> $stable(cnt));  // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (g_run && !wr_clo && !wr_chi) |=> (cnt == $past(cnt) + 64'd1));  // R2
  AST_LEG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (g_leg && sts[0]) |-> (leg_tick_o && !irq_o[0]));  // R9

endmodule

// File: tb/sim_evt_timer.sv
module sim_evt_timer;
  localparam int NCH = 3;
  localparam logic [31:0] TFS = 32'd69841279;

  logic clk = 0, rst_n = 0, we = 0;
  logic [11:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [NCH-1:0] irq;
  logic lt, lr;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  evt_timer #(.NCH(NCH), .TICK_FS(TFS), .AW(12)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .irq_o(irq), .leg_tick_o(lt), .leg_rtc_o(lr));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1;
    @(posedge clk);
    @(negedge clk);
    we = 0; addr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata; addr = 0;
  endtask

  task automatic park_zero();
    wr(12'h010, 0); wr(12'h0F0, 0); wr(12'h0F4, 0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(12'h000, v); chk("R1 id", v, 32'h102);
    rd(12'h004, v); chk("R1 period", v, TFS);
    rd(12'h0F0, v); chk("R3 cnt lo reset", v, 0);
    chk("R10 irq reset", 32'(irq), 0);
    wr(12'h000, 32'hFFFF); wr(12'h004, 32'h1);
    rd(12'h000, v); chk("R1 id write ignored", v, 32'h102);
    rd(12'h004, v); chk("R1 period write ignored", v, TFS);
  endtask

  task automatic t_counter();
    logic [31:0] v, w;
    wr(12'h010, 0); wr(12'h0F0, 32'hFFFF_FFFE); wr(12'h0F4, 5);
    repeat (3) @(negedge clk);
    rd(12'h0F0, v); chk("R2 hold while stopped", v, 32'hFFFF_FFFE);
    wr(12'h010, 1);
    repeat (3) @(negedge clk);
    rd(12'h0F0, v); chk("R3 lo after carry", v, 1);
    rd(12'h0F4, v); chk("R2 carry into hi", v, 6);
    wr(12'h010, 0);
    rd(12'h0F0, v);
    repeat (5) @(negedge clk);
    rd(12'h0F0, w); chk("R2 stopped no count", w, v);
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    park_zero();
    wr(12'h100, 1); wr(12'h108, 10);
    wr(12'h010, 1);
    repeat (10) @(negedge clk);
    rd(12'h020, v); chk("R4 not yet pending", v, 0);
    @(negedge clk);
    rd(12'h020, v); chk("R4 pending after match", v, 1);
    chk("R10 irq0 level", 32'(irq), 1);
    rd(12'h108, v); chk("R4 cmp unchanged", v, 10);
    wr(12'h020, 0);
    rd(12'h020, v); chk("R8 write zero keeps", v, 1);
    wr(12'h020, 1);
    rd(12'h020, v); chk("R8 w1c clears", v, 0);
    chk("R10 irq drops", 32'(irq), 0);
  endtask

  task automatic t_periodic();
    logic [31:0] v;
    wr(12'h100, 0);
    park_zero();
    wr(12'h120, 32'h0F);
    rd(12'h120, v); chk("R6 setval reads zero", v, 32'h0B);
    wr(12'h128, 20); wr(12'h128, 15);
    rd(12'h128, v); chk("R6 second write is period", v, 20);
    wr(12'h010, 1);
    repeat (20) @(negedge clk);
    rd(12'h020, v); chk("R5 not yet", v, 0);
    @(negedge clk);
    rd(12'h020, v); chk("R5 first match", v, 2);
    rd(12'h128, v); chk("R5 cmp advanced", v, 35);
    wr(12'h020, 2);
    repeat (14) @(negedge clk);
    rd(12'h020, v); chk("R5 second match", v, 2);
    rd(12'h128, v); chk("R5 cmp advanced again", v, 50);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    wr(12'h120, 0);
    park_zero();
    wr(12'h020, 7);
    wr(12'h140, 2); wr(12'h148, 5);
    wr(12'h010, 1);
    repeat (10) @(negedge clk);
    rd(12'h020, v); chk("R7 no pending", v, 0);
    chk("R7 no irq", 32'(irq), 0);
    rd(12'h148, v); chk("R7 cmp still", v, 5);
    rd(12'h128, v); chk("R7 disabled ch1 cmp", v, 50);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    park_zero();
    wr(12'h140, 7); wr(12'h148, 8); wr(12'h148, 8);
    wr(12'h020, 7);
    wr(12'h010, 1);
    repeat (10) @(negedge clk);
    rd(12'h020, v); chk("R8 first match pending", v, 4);
    repeat (6) @(negedge clk);
    wr(12'h020, 4);
    rd(12'h020, v); chk("R8 set wins over clear", v, 4);
    wr(12'h020, 4);
    rd(12'h020, v); chk("R8 later clear", v, 0);
    rd(12'h148, v); chk("R5 cmp after collision", v, 24);
  endtask

  task automatic t_legacy();
    logic [31:0] v;
    wr(12'h140, 0);
    park_zero();
    wr(12'h100, 1); wr(12'h108, 3);
    wr(12'h120, 1); wr(12'h128, 4);
    wr(12'h010, 1);
    repeat (8) @(negedge clk);
    wr(12'h010, 0);
    chk("R10 irq both", 32'(irq), 3);
    chk("R9 leg lines idle", {30'd0, lt, lr}, 0);
    wr(12'h010, 2);
    chk("R9 irq masked", 32'(irq), 0);
    chk("R9 leg lines", {30'd0, lt, lr}, 3);
    wr(12'h020, 1);
    chk("R9 tick cleared", {30'd0, lt, lr}, 1);
    wr(12'h010, 0);
    chk("R10 irq1 back", 32'(irq), 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_counter();
    t_oneshot();
    t_periodic();
    t_disabled();
    t_collision();
    t_legacy();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule